// File: doc/BRIEF.md
# Nesting Vectored Priority Interrupt Controller

This block collects interrupt requests from a set of sources and gives a processor one active-low request line. Each source has its own programmable handler address, a priority from 0 (lowest) to 7 (highest), and an enable bit. Among the enabled pending sources, the one with the highest priority wins, and the lowest source number breaks ties. The request line is asserted only when the winner ranks strictly above the level currently being serviced.

The processor acknowledges an interrupt by reading the acknowledge register. That read returns the winner's handler address, clears the winner's pending flag, and pushes the winner's number and priority onto an internal stack eight entries deep. This raises the current level. Writing the end-of-interrupt register pops the stack, which returns the controller to the interrupted context. A source of higher priority can therefore preempt a handler in progress, so up to eight handlers can be nested. Configuration uses a simple register bus: a write strobe, a read strobe and a byte address. Reads are combinational.

Top module: `nvpic_top`

## Requirements
- R1: After reset, irq_n is high, no source is pending, and the stack is empty. Every handler address, priority field, enable mask and the spurious vector reads as zero.
- R2: Byte address 0x000+4n holds the 32-bit handler address of source n, and 0x080+4n holds its priority in bits [2:0]; the upper bits read as zero. The enable mask is at 0x10C (bit n enables source n) and the spurious vector is at 0x108. All of these are writable and read back.
- R3: A one-cycle high pulse on src_req[n] sets the pending flag of source n. The flag stays set, even while the source is disabled, until a read of 0x100 acknowledges source n.
- R4: With the stack empty, irq_n goes low in the cycle after an enabled source becomes pending, whatever its priority. A pending source whose enable bit is clear does not affect irq_n.
- R5: The winner is the enabled pending source with the highest priority value. Among equal priorities, the lowest source number wins.
- R6: A read of 0x100 while irq_n is low returns the winner's handler address, clears its pending flag, and pushes its number and priority onto the stack.
- R7: After an acknowledge, irq_n stays high until a source with strictly higher priority than the pushed one becomes pending, or until an end-of-interrupt lowers the current level.
- R8: While the stack is non-empty, irq_n goes low exactly when an enabled pending source has a priority strictly above the top entry's priority.
- R9: A write of any value to 0x104 pops the stack and restores the previous number and level. Address 0x110 reads bit 8 = stack non-empty and the low bits = number of the source on top of the stack (zero when the stack is empty).
- R10: A read of 0x100 while irq_n is high returns the spurious vector and leaves the stack and the pending flags unchanged.
- R11: A write to 0x104 while the stack is empty has no effect.
- R12: The stack holds eight nested entries and never takes a ninth. With eight entries stacked, no source can assert irq_n and an acknowledge returns the spurious vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NSRC | Per-source request pulses that set the pending flags |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of 0x100 acknowledges |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench builds the controller with eight sources, eight priority levels and a stack eight deep. With these values it can drive every one of the 255 non-empty pending patterns, each under its own priority assignment. Half of these assignments contain ties, so the full acknowledge and end-of-interrupt drain order is checked against a winner computed in the bench. Priorities set equal to the source numbers let a single run stack eight nested handlers, hit the full-stack limit, and unwind every level through the current-source register.

// File: rtl/nvpic_pkg.sv
// Package: address map and access decode shared by the controller modules.
// Assumes byte addressing with word-aligned registers and at most 32 sources.
package nvpic_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_VEC,
        ACC_PRIO,
        ACC_ACK,
        ACC_EOI,
        ACC_SPUR,
        ACC_ENA,
        ACC_CUR
    } acc_e;

    localparam logic [15:0] OFS_PRIO = 16'h0080;
    localparam logic [15:0] OFS_ACK  = 16'h0100;
    localparam logic [15:0] OFS_EOI  = 16'h0104;
    localparam logic [15:0] OFS_SPUR = 16'h0108;
    localparam logic [15:0] OFS_ENA  = 16'h010C;
    localparam logic [15:0] OFS_CUR  = 16'h0110;

    // Map a byte address onto the register it selects.
    function automatic acc_e decode_addr(input logic [15:0] a);
        logic [15:0] w;
        w = {a[15:2], 2'b00};
        if (w < OFS_PRIO)      return ACC_VEC;
        else if (w < OFS_ACK)  return ACC_PRIO;
        else if (w == OFS_ACK)  return ACC_ACK;
        else if (w == OFS_EOI)  return ACC_EOI;
        else if (w == OFS_SPUR) return ACC_SPUR;
        else if (w == OFS_ENA)  return ACC_ENA;
        else if (w == OFS_CUR)  return ACC_CUR;
        else                    return ACC_NONE;
    endfunction

endpackage

// File: rtl/nvpic_regs.sv
// Configuration registers: per-source handler address and priority, the
// enable mask and the spurious vector. Assumes NSRC <= 32 and that idx is
// the word index taken from the address. Reads are combinational.
module nvpic_regs
    import nvpic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NLVL = 8,
    parameter int DW   = 32,
    localparam int SW  = $clog2(NSRC),
    localparam int PW  = $clog2(NLVL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  acc_e                     acc,
    input  logic [4:0]               idx,
    input  logic [DW-1:0]            wdata,
    input  logic [SW-1:0]            sel_idx,
    output logic [DW-1:0]            sel_vec,
    output logic [NSRC-1:0][PW-1:0]  prio,
    output logic [NSRC-1:0]          ena,
    output logic [DW-1:0]            spur,
    output logic [DW-1:0]            rd_cfg
);

    logic [DW-1:0] vec_q [NSRC];
    logic          idx_ok;

    assign idx_ok = (32'(idx) < NSRC);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Store the handler address and priority of source g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[g] <= '0;
                prio[g]  <= '0;
            end else if (wr && idx == 5'(g)) begin
                if (acc == ACC_VEC)  vec_q[g] <= wdata;
                if (acc == ACC_PRIO) prio[g]  <= wdata[PW-1:0];
            end
        end
    end

    // Store the enable mask and the spurious vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena  <= '0;
            spur <= '0;
        end else if (wr) begin
            if (acc == ACC_ENA)  ena  <= wdata[NSRC-1:0];
            if (acc == ACC_SPUR) spur <= wdata;
        end
    end

    assign sel_vec = vec_q[sel_idx];

    // Read back the configuration register that the address selects.
    always_comb begin
        rd_cfg = '0;
        case (acc)
            ACC_VEC:  if (idx_ok) rd_cfg = vec_q[idx[SW-1:0]];
            ACC_PRIO: if (idx_ok) rd_cfg = DW'(prio[idx[SW-1:0]]);
            ACC_ENA:  rd_cfg = DW'(ena);
            ACC_SPUR: rd_cfg = spur;
            default:  rd_cfg = '0;
        endcase
    end

endmodule

// File: rtl/nvpic_arb.sv
// Priority arbiter: picks the request with the highest priority value; ties
// go to the lowest index. Purely combinational.
module nvpic_arb #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]          req,
    input  logic [NSRC-1:0][PW-1:0]  prio,
    output logic                     win_valid,
    output logic [SW-1:0]            win_idx,
    output logic [PW-1:0]            win_prio
);

    // Scan upward, replacing the best only on a strictly higher priority.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!win_valid || prio[i] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = SW'(i);
                win_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/nvpic_stack.sv
// Nesting stack: holds source number and priority of each interrupt in
// service. Assumes the caller never pushes when full or pops when empty.
module nvpic_stack #(
    parameter int DEPTH = 8,
    parameter int SW    = 5,
    parameter int PW    = 3,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [SW-1:0]   push_num,
    input  logic [PW-1:0]   push_lvl,
    output logic [SW-1:0]   top_num,
    output logic [PW-1:0]   top_lvl,
    output logic            empty,
    output logic [DPW-1:0]  depth
);

    logic [SW-1:0] num_q [DEPTH];
    logic [PW-1:0] lvl_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Capture a pushed entry into slot g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                num_q[g] <= '0;
                lvl_q[g] <= '0;
            end else if (push && depth == DPW'(g)) begin
                num_q[g] <= push_num;
                lvl_q[g] <= push_lvl;
            end
        end
    end

    // Track the number of occupied entries.
    always_ff @(posedge clk) begin
        if (!rst_n)     depth <= '0;
        else if (push)  depth <= depth + 1'b1;
        else if (pop)   depth <= depth - 1'b1;
    end

    assign empty = (depth == '0);

    // Present the newest entry, or zeros when empty.
    always_comb begin
        top_num = '0;
        top_lvl = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth == DPW'(i + 1)) begin
                top_num = num_q[i];
                top_lvl = lvl_q[i];
            end
        end
    end

endmodule

// File: rtl/nvpic_top.sv
// Nesting vectored priority interrupt controller top. Holds pending flags,
// arbitrates, drives irq_n and handles acknowledge and end-of-interrupt.
// Assumes 2 <= NSRC <= 32, AW between 9 and 16, DEPTH >= NLVL.
module nvpic_top
    import nvpic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NLVL  = 8,
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int AW    = 9,
    localparam int SW   = $clog2(NSRC),
    localparam int PW   = $clog2(NLVL),
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_n
);

    acc_e                    acc;
    logic [NSRC-1:0]         pending_q;
    logic [NSRC-1:0]         clr_mask;
    logic [NSRC-1:0][PW-1:0] prio;
    logic [NSRC-1:0]         ena;
    logic [DW-1:0]           spur, sel_vec, rd_cfg;
    logic                    win_valid, stk_empty, stk_full, eligible;
    logic [SW-1:0]           win_idx, top_num;
    logic [PW-1:0]           win_prio, top_lvl;
    logic [DPW-1:0]          depth;
    logic                    ack, eoi, push, pop;

    assign acc = decode_addr(16'(bus_addr));

    nvpic_regs #(.NSRC(NSRC), .NLVL(NLVL), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .acc(acc),
        .idx(bus_addr[6:2]), .wdata(bus_wdata), .sel_idx(win_idx),
        .sel_vec(sel_vec), .prio(prio), .ena(ena), .spur(spur),
        .rd_cfg(rd_cfg)
    );

    nvpic_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
        .req(pending_q & ena), .prio(prio), .win_valid(win_valid),
        .win_idx(win_idx), .win_prio(win_prio)
    );

    nvpic_stack #(.DEPTH(DEPTH), .SW(SW), .PW(PW)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_num(win_idx), .push_lvl(win_prio), .top_num(top_num),
        .top_lvl(top_lvl), .empty(stk_empty), .depth(depth)
    );

    assign stk_full = (depth == DPW'(DEPTH));
    assign eligible = win_valid && !stk_full && (stk_empty || win_prio > top_lvl);
    assign irq_n    = !eligible;
    assign ack      = bus_rd && (acc == ACC_ACK);
    assign eoi      = bus_wr && (acc == ACC_EOI);
    assign push     = ack && eligible;
    assign pop      = eoi && !stk_empty;
    assign clr_mask = push ? (NSRC'(1) << win_idx) : '0;

    // Set pending flags from request pulses; clear the acknowledged one.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~clr_mask) | src_req;
    end

    // Select read data: vector on acknowledge, context on current-source.
    always_comb begin
        bus_rdata = rd_cfg;
        if (acc == ACC_ACK) begin
            bus_rdata = eligible ? sel_vec : spur;
        end else if (acc == ACC_CUR) begin
            bus_rdata         = '0;
            bus_rdata[8]      = !stk_empty;
            bus_rdata[SW-1:0] = top_num;
        end
    end

endmodule

// File: rtl/nvpic_checker.sv
// Checker for the controller: relates the arbiter, the stack and the request
// line over time. Bound into every nvpic_top instance.
module nvpic_checker #(
    parameter int DEPTH = 8,
    parameter int PW    = 3,
    parameter int DPW   = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_n,
    input logic           win_valid,
    input logic [PW-1:0]  win_prio,
    input logic [PW-1:0]  top_lvl,
    input logic [DPW-1:0] depth,
    input logic           push,
    input logic           pop,
    input logic           eoi
);

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == DPW'(DEPTH)) |-> !push);

    assert_push_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (depth == DPW'($past(depth) + 1'b1)));

    assert_pop_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (depth == DPW'($past(depth) - 1'b1)));

    assert_eoi_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && depth == '0) |=> (depth == '0));

    assert_idle_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0 && win_valid) |-> !irq_n);

    assert_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (depth != '0 && depth != DPW'(DEPTH) && win_valid && win_prio > top_lvl) |-> !irq_n);

    assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (depth != '0 && (!win_valid || win_prio <= top_lvl)) |-> irq_n);

    assert_nest_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && depth != '0) |-> (win_prio > top_lvl));

endmodule

bind nvpic_top nvpic_checker #(.DEPTH(DEPTH), .PW(PW), .DPW(DPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .win_valid(win_valid),
    .win_prio(win_prio), .top_lvl(top_lvl), .depth(depth),
    .push(push), .pop(pop), .eoi(eoi)
);

// File: tb/nvpic_top_tb_top.sv
`timescale 1ns/1ps
// Bench: eight sources, eight levels, eight-deep stack. Sweeps all pending
// patterns with computed priorities and checks a full nesting ladder.
module nvpic_top_tb_top;

    localparam int NSRC = 8;
    localparam int AW   = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    nvpic_top #(.NSRC(NSRC), .NLVL(8), .DEPTH(8), .DW(32), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        src_req = m;
        @(negedge clk);
        src_req = '0;
    endtask

    function automatic int pr(input int i, input int p);
        if (p % 2 == 1) return (i * 3 + p) % 8;
        else            return (i % 3 + p) % 8;
    endfunction

    function automatic int exp_win(input int mask, input int p);
        int best = -1;
        for (int i = 0; i < NSRC; i++)
            if (mask[i] && (best < 0 || pr(i, p) > pr(best, p))) best = i;
        return best;
    endfunction

    function automatic logic [31:0] vec(input int i);
        return 32'hA000_0000 | 32'(i << 4);
    endfunction

    localparam logic [31:0] SPUR = 32'h5A5A_0F0F;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int rem, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_n", 32'(irq_n), 32'd1);
        rd(9'h108, d); check("R1 spurious", d, 32'd0);
        rd(9'h10C, d); check("R1 enable", d, 32'd0);
        rd(9'h08C, d); check("R1 prio3", d, 32'd0);
        rd(9'h014, d); check("R1 vec5", d, 32'd0);
        rd(9'h110, d); check("R1 current", d, 32'd0);

        // R2: program and read back all registers
        for (int i = 0; i < NSRC; i++) begin
            wr(AW'(4 * i), vec(i));
            wr(AW'(9'h080 + 4 * i), 32'hFFFF_FFF8 | 32'(i));
        end
        for (int i = 0; i < NSRC; i++) begin
            rd(AW'(4 * i), d); check("R2 vector", d, vec(i));
            rd(AW'(9'h080 + 4 * i), d); check("R2 priority", d, 32'(i));
        end
        wr(9'h108, SPUR);
        rd(9'h108, d); check("R2 spurious", d, SPUR);

        // R3/R4: disabled pending source is held but does not request
        pulse(8'h04);
        check("R4 disabled no irq", 32'(irq_n), 32'd1);
        rd(9'h100, d); check("R10 spurious when idle", d, SPUR);
        rd(9'h110, d); check("R10 no push", d, 32'd0);
        wr(9'h10C, 32'h0000_0004);
        rd(9'h10C, d); check("R2 enable", d, 32'h4);
        check("R3 pending held", 32'(irq_n), 32'd0);
        rd(9'h100, d); check("R6 vector", d, vec(2));
        wr(9'h104, 32'd0);
        check("R3 pending cleared", 32'(irq_n), 32'd1);

        // R5/R6/R7/R9/R10: sweep every pending pattern
        wr(9'h10C, 32'h0000_00FF);
        for (int p = 1; p < 256; p++) begin
            for (int i = 0; i < NSRC; i++) wr(AW'(9'h080 + 4 * i), 32'(pr(i, p)));
            pulse(NSRC'(p));
            check("R4 request", 32'(irq_n), 32'd0);
            rem = p;
            while (rem != 0) begin
                w = exp_win(rem, p);
                rd(9'h100, d); check("R5 winner vector", d, vec(w));
                check("R7 held after ack", 32'(irq_n), 32'd1);
                rem = rem & ~(1 << w);
                wr(9'h104, 32'd0);
                check("R9 re-request after eoi", 32'(irq_n), (rem == 0) ? 32'd1 : 32'd0);
            end
            rd(9'h100, d); check("R10 spurious after drain", d, SPUR);
        end

        // R8/R12: full nesting ladder, priority equals source number
        for (int i = 0; i < NSRC; i++) wr(AW'(9'h080 + 4 * i), 32'(i));
        for (int k = 0; k < NSRC; k++) begin
            pulse(NSRC'(1 << k));
            check("R8 preempt request", 32'(irq_n), 32'd0);
            rd(9'h100, d); check("R6 nested vector", d, vec(k));
            check("R7 held after nested ack", 32'(irq_n), 32'd1);
            rd(9'h110, d); check("R9 current source", d, 32'h100 | 32'(k));
        end
        pulse(8'h01);
        check("R12 full stack no irq", 32'(irq_n), 32'd1);
        rd(9'h100, d); check("R12 full stack spurious", d, SPUR);
        rd(9'h110, d); check("R12 top unchanged", d, 32'h107);
        for (int k = NSRC - 1; k >= 1; k--) begin
            wr(9'h104, 32'd0);
            rd(9'h110, d); check("R9 restored source", d, 32'h100 | 32'(k - 1));
            check("R7 lower pending held", 32'(irq_n), 32'd1);
        end
        wr(9'h104, 32'd0);
        rd(9'h110, d); check("R9 stack emptied", d, 32'd0);
        check("R4 low priority after unwind", 32'(irq_n), 32'd0);
        rd(9'h100, d); check("R6 vector src0", d, vec(0));
        wr(9'h104, 32'd0);

        // R11: end-of-interrupt with empty stack is ignored
        wr(9'h104, 32'd0);
        rd(9'h110, d); check("R11 still empty", d, 32'd0);
        check("R11 irq idle", 32'(irq_n), 32'd1);
        pulse(8'h20);
        check("R11 request after stray eoi", 32'(irq_n), 32'd0);
        rd(9'h100, d); check("R11 vector", d, vec(5));
        rd(9'h110, d); check("R11 single push", d, 32'h105);
        wr(9'h104, 32'd0);
        rd(9'h110, d); check("R11 single pop", d, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule